// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Valley-Buffered Compares

This block is a 16-bit up/down counter for center-aligned PWM. It counts up from zero to a programmable period value. At that peak it raises an overflow flag and turns around to count down. At the valley it steps from 0 to the all-ones value and then climbs back through 0 and 1. Only the step from 0 to all-ones while falling counts as an underflow. That step raises the underflow flag. When the transfer mode selects valley transfer, the same step also loads the three active compare registers from their shadow buffers. The return through all-ones, 0 and 1 changes neither the flags nor the compares.

Software may write the shadow buffers at any time. The new values reach the PWM comparison only at a qualifying underflow, so a duty-cycle change never tears in the middle of a carrier period. Each channel drives a pair of outputs. The true output is high while the count is below that channel's active compare, and the partner output is its inverse. Every output is registered and lines up with the count shown on the port in the same cycle.

Top module: `cpwm_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `count`, both flags, every active compare and every buffer to 0, and selects counting up. After that edge `pwm_p` is all 0 and `pwm_n` is all 1.
- R2: On a cycle where `cnt_en` is low, `count` and `cmp_act` keep their values.
- R3: When counting up with `count` below `period`, each enabled cycle adds 1. The edge at which `count` becomes equal to `period` sets `flag_ovf`.
- R4: When counting up with `count` at or above `period`, an enabled cycle subtracts 1 and switches to counting down. While counting down above 0, each enabled cycle subtracts 1.
- R5: At the valley, successive enabled cycles give 1, 0, FFFFh, 0, 1 on `count`, and counting up resumes after FFFFh.
- R6: `flag_unf` is set only by the enabled step from 0 to FFFFh while counting down. The step from FFFFh to 0 and the step from 0 to 1 leave `flag_unf` and `flag_ovf` as they were, apart from explicit clears.
- R7: When `xfer_mode` equals 2'b10, the underflow step copies each channel's buffer into its active compare. The copy uses the buffer contents held before that cycle's write, and `cmp_act` shows the new values in the same cycle that `count` shows FFFFh.
- R8: When `xfer_mode` is 2'b00, 2'b01 or 2'b11, the underflow step leaves `cmp_act` unchanged.
- R9: `cmp_act` changes only on a transfer step. A buffer write through `buf_we`/`buf_wdata` at any other time leaves `cmp_act` unchanged. Channel c occupies `cmp_act[16c+15:16c]`, and bit c of `buf_we` selects channel c.
- R10: Each flag stays at 1 until its clear strobe (`clr_unf`, `clr_ovf`) is high at a clock edge. A set event in the same cycle as that flag's clear leaves the flag at 1.
- R11: For each channel c, `pwm_p[c]` is 1 exactly when `count` is below channel c's `cmp_act` field in the same cycle, and `pwm_n[c]` is always the inverse of `pwm_p[c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; the counter steps only when high |
| period | input | 16 | Peak count value |
| xfer_mode | input | 2 | Transfer mode; 2'b10 selects buffer-to-compare load at underflow |
| buf_we | input | 3 | Per-channel buffer write strobe |
| buf_wdata | input | 16 | Data written into the selected buffers |
| clr_unf | input | 1 | Clear strobe for the underflow flag |
| clr_ovf | input | 1 | Clear strobe for the overflow flag |
| count | output | 16 | Current counter value |
| cmp_act | output | 48 | Active compare values, channel c in bits 16c+15:16c |
| flag_unf | output | 1 | Sticky underflow flag |
| flag_ovf | output | 1 | Sticky overflow flag |
| pwm_p | output | 3 | True PWM output per channel |
| pwm_n | output | 3 | Complementary PWM output per channel |

## Verification
The peak and overflow properties assume that `period` lies between 2 and FFFEh and holds steady while the counter runs. If `period` drops below a running up-count, or equals the wrap value, the one-step increment relation does not apply. The stimulus keeps `period` fixed at a small value for the whole run, so many full carrier periods fit in a short test. Clear strobes and buffer writes are driven freely, including in the exact underflow cycle, because the properties only assume the flag-set and transfer rules the block states itself.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;

  localparam logic [1:0] XFER_VALLEY = 2'b10;
endpackage

// File: rtl/cpwm_updn_cnt.sv
module cpwm_updn_cnt
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output dir_e             dir_q,
  output logic             unf_evt,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  dir_e dir_nxt;

  // Next-state decode: valley wrap, return path, peak reversal, plain steps.
  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    unf_evt = 1'b0;
    ovf_evt = 1'b0;
    if (en) begin
      if (dir_q == DIR_DN) begin
        if (cnt_q == '0) begin
          cnt_nxt = CNT_TOP;
          dir_nxt = DIR_UP;
          unf_evt = 1'b1;
        end else begin
          cnt_nxt = cnt_q - CNT_ONE;
        end
      end else begin
        if (cnt_q == CNT_TOP) begin
          cnt_nxt = '0;
        end else if (cnt_q >= prd) begin
          cnt_nxt = cnt_q - CNT_ONE;
          dir_nxt = DIR_DN;
        end else begin
          cnt_nxt = cnt_q + CNT_ONE;
          ovf_evt = ((cnt_q + CNT_ONE) == prd);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_nxt;
    end
  end
endmodule

// File: rtl/cpwm_cmp_bank.sv
module cpwm_cmp_bank #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] buf_we,
  input  logic [CNT_W-1:0]  buf_wdata,
  input  logic              load,
  output logic [CNT_W-1:0]  cmp_q   [NUM_CH],
  output logic [CNT_W-1:0]  cmp_nxt [NUM_CH]
);
  logic [CNT_W-1:0] shadow_q [NUM_CH];

  // The load picks up the shadow value held before this cycle's write.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      cmp_nxt[c] = load ? shadow_q[c] : cmp_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        shadow_q[c] <= '0;
        cmp_q[c]    <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (buf_we[c]) shadow_q[c] <= buf_wdata;
        cmp_q[c] <= cmp_nxt[c];
      end
    end
  end
endmodule

// File: rtl/cpwm_flags.sv
module cpwm_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_unf,
  input  logic set_ovf,
  input  logic clr_unf,
  input  logic clr_ovf,
  output logic unf_q,
  output logic ovf_q
);
  // A set outranks a clear in the same cycle so no event is lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      unf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (set_unf)      unf_q <= 1'b1;
      else if (clr_unf) unf_q <= 1'b0;
      if (set_ovf)      ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cpwm_pwm_out.sv
module cpwm_pwm_out #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic [CNT_W-1:0]  cmp_nxt [NUM_CH],
  output logic [NUM_CH-1:0] pwm_p,
  output logic [NUM_CH-1:0] pwm_n
);
  logic [NUM_CH-1:0] level;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      level[c] = (cnt_nxt < cmp_nxt[c]);
    end
  end

  // Compare on next-state values so the pins align with count/cmp ports.
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_p <= '0;
      pwm_n <= '1;
    end else begin
      pwm_p <= level;
      pwm_n <= ~level;
    end
  end
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cnt_en,
  input  logic [CNT_W-1:0]        period,
  input  logic [1:0]              xfer_mode,
  input  logic [NUM_CH-1:0]       buf_we,
  input  logic [CNT_W-1:0]        buf_wdata,
  input  logic                    clr_unf,
  input  logic                    clr_ovf,
  output logic [CNT_W-1:0]        count,
  output logic [NUM_CH*CNT_W-1:0] cmp_act,
  output logic                    flag_unf,
  output logic                    flag_ovf,
  output logic [NUM_CH-1:0]       pwm_p,
  output logic [NUM_CH-1:0]       pwm_n
);
  logic [CNT_W-1:0] cnt_nxt;
  dir_e             dir_q;
  logic             unf_evt;
  logic             ovf_evt;
  logic             cnt_down;
  logic             load;
  logic [CNT_W-1:0] cmp_q   [NUM_CH];
  logic [CNT_W-1:0] cmp_nxt [NUM_CH];

  assign cnt_down = (dir_q == DIR_DN);
  assign load     = unf_evt && (xfer_mode == XFER_VALLEY);

  cpwm_updn_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en      (cnt_en),
    .prd     (period),
    .cnt_q   (count),
    .cnt_nxt (cnt_nxt),
    .dir_q   (dir_q),
    .unf_evt (unf_evt),
    .ovf_evt (ovf_evt)
  );

  cpwm_cmp_bank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .buf_we    (buf_we),
    .buf_wdata (buf_wdata),
    .load      (load),
    .cmp_q     (cmp_q),
    .cmp_nxt   (cmp_nxt)
  );

  cpwm_flags u_flg (
    .clk     (clk),
    .rst     (rst),
    .set_unf (unf_evt),
    .set_ovf (ovf_evt),
    .clr_unf (clr_unf),
    .clr_ovf (clr_ovf),
    .unf_q   (flag_unf),
    .ovf_q   (flag_ovf)
  );

  cpwm_pwm_out #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_pwm (
    .clk     (clk),
    .rst     (rst),
    .cnt_nxt (cnt_nxt),
    .cmp_nxt (cmp_nxt),
    .pwm_p   (pwm_p),
    .pwm_n   (pwm_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
    assign cmp_act[c*CNT_W +: CNT_W] = cmp_q[c];
  end
endmodule

// File: rtl/cpwm_timer_chk.sv
module cpwm_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cnt_en,
  input logic [CNT_W-1:0]        period,
  input logic [1:0]              xfer_mode,
  input logic                    clr_unf,
  input logic                    clr_ovf,
  input logic [CNT_W-1:0]        count,
  input logic [NUM_CH*CNT_W-1:0] cmp_act,
  input logic                    flag_unf,
  input logic                    flag_ovf,
  input logic [NUM_CH-1:0]       pwm_p,
  input logic [NUM_CH-1:0]       pwm_n,
  input logic                    cnt_down
);
  localparam logic [CNT_W-1:0] TOP = '1;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(count) && $stable(cmp_act)));

  p_peak_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !cnt_down && count != TOP && (count + CNT_W'(1)) == period)
    |=> (count == period && flag_ovf));

  p_turn_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !cnt_down && count == period)
    |=> (cnt_down && count == $past(count) - CNT_W'(1)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_down && count == '0) |=> (count == TOP && !cnt_down));

  p_return_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == TOP) |=> (count == '0));

  p_unf_set_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_down && count == '0) |=> flag_unf);

  p_unf_only_r6: assert property (@(posedge clk) disable iff (rst)
    (!(cnt_en && cnt_down && count == '0) && !flag_unf) |=> !flag_unf);

  p_return_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count == TOP && !clr_unf && !clr_ovf)
    |=> ($stable(flag_unf) && $stable(flag_ovf)));

  p_cmp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(cnt_en && cnt_down && count == '0 && xfer_mode == 2'b10)
    |=> $stable(cmp_act));

  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_unf && !clr_unf) |=> flag_unf);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_ovf && !clr_ovf) |=> flag_ovf);

  p_pair_r11: assert property (@(posedge clk) disable iff (rst)
    pwm_n == ~pwm_p);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lvl
    p_level_r11: assert property (@(posedge clk) disable iff (rst)
      pwm_p[c] == (count < cmp_act[c*CNT_W +: CNT_W]));
  end
endmodule

bind cpwm_timer cpwm_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/cpwm_timer_tb.sv
module cpwm_timer_tb;
  localparam int W = 16;
  localparam int N = 3;
  localparam logic [W-1:0] PRD = 16'd6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst;
  logic         cnt_en;
  logic [W-1:0] period;
  logic [1:0]   xfer_mode;
  logic [N-1:0] buf_we;
  logic [W-1:0] buf_wdata;
  logic         clr_unf;
  logic         clr_ovf;
  logic [W-1:0]   count;
  logic [N*W-1:0] cmp_act;
  logic         flag_unf;
  logic         flag_ovf;
  logic [N-1:0] pwm_p;
  logic [N-1:0] pwm_n;

  cpwm_timer #(.CNT_W(W), .NUM_CH(N)) u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .period(period),
    .xfer_mode(xfer_mode), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .clr_unf(clr_unf), .clr_ovf(clr_ovf), .count(count), .cmp_act(cmp_act),
    .flag_unf(flag_unf), .flag_ovf(flag_ovf), .pwm_p(pwm_p), .pwm_n(pwm_n)
  );

  typedef struct packed {
    logic [W-1:0]   cnt;
    logic [N*W-1:0] cmp;
    logic           unf;
    logic           ovf;
    logic [N-1:0]   pp;
    logic [N-1:0]   pn;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // Reference state built from the requirements.
  logic [W-1:0] m_cnt;
  logic         m_dn;
  logic         m_unf;
  logic         m_ovf;
  logic [W-1:0] m_buf [N];
  logic [W-1:0] m_cmp [N];

  task automatic step(input logic en, input logic [1:0] md, input logic [N-1:0] we,
                      input logic [W-1:0] wd, input logic cu, input logic co);
    logic [W-1:0] nc;
    logic ndn, uev, oev;
    string tag;
    exp_t e;
    @(negedge clk);
    cnt_en = en; xfer_mode = md; buf_we = we; buf_wdata = wd;
    clr_unf = cu; clr_ovf = co;
    nc = m_cnt; ndn = m_dn; uev = 1'b0; oev = 1'b0; tag = "R3";
    if (!en) tag = "R2";
    else if (m_dn) begin
      if (m_cnt == '0) begin
        nc = '1; ndn = 1'b0; uev = 1'b1;
        tag = (md == 2'b10) ? "R5 R6 R7" : "R5 R6 R8";
      end else begin
        nc = m_cnt - 1'b1; tag = "R4";
      end
    end else begin
      if (m_cnt == '1) begin
        nc = '0; tag = "R5 R6 R9";
      end else if (m_cnt >= PRD) begin
        nc = m_cnt - 1'b1; ndn = 1'b1; tag = "R4";
      end else begin
        nc = m_cnt + 1'b1;
        if (nc == PRD) oev = 1'b1;
      end
    end
    if (uev && md == 2'b10) for (int c = 0; c < N; c++) m_cmp[c] = m_buf[c];
    else if (|we) tag = {tag, " R9"};
    for (int c = 0; c < N; c++) if (we[c]) m_buf[c] = wd;
    if (uev) m_unf = 1'b1; else if (cu) m_unf = 1'b0;
    if (oev) m_ovf = 1'b1; else if (co) m_ovf = 1'b0;
    if (cu || co) tag = {tag, " R10"};
    m_cnt = nc; m_dn = ndn;
    e.cnt = nc; e.unf = m_unf; e.ovf = m_ovf;
    for (int c = 0; c < N; c++) begin
      e.cmp[c*W +: W] = m_cmp[c];
      e.pp[c] = (nc < m_cmp[c]);
      e.pn[c] = !(nc < m_cmp[c]);
    end
    exp_q.push_back(e);
    tag_q.push_back({tag, " R11"});
  endtask

  // Monitor: compare each result just after the edge that produced it.
  initial begin
    exp_t e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (count !== e.cnt || cmp_act !== e.cmp || flag_unf !== e.unf ||
            flag_ovf !== e.ovf || pwm_p !== e.pp || pwm_n !== e.pn) begin
          n_fail++;
          $display("FAIL %s: count=%h exp %h cmp=%h exp %h unf=%b exp %b ovf=%b exp %b p=%b exp %b n=%b exp %b",
                   t, count, e.cnt, cmp_act, e.cmp, flag_unf, e.unf, flag_ovf, e.ovf,
                   pwm_p, e.pp, pwm_n, e.pn);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cnt_en = 1'b0; period = PRD; xfer_mode = 2'b10; buf_we = '0;
    buf_wdata = '0; clr_unf = 1'b0; clr_ovf = 1'b0;
    m_cnt = '0; m_dn = 1'b0; m_unf = 1'b0; m_ovf = 1'b0;
    for (int c = 0; c < N; c++) begin m_buf[c] = '0; m_cmp[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    n_chk++;
    if (count !== '0 || cmp_act !== '0 || flag_unf !== 1'b0 || flag_ovf !== 1'b0 ||
        pwm_p !== '0 || pwm_n !== '1) begin
      n_fail++;
      $display("FAIL R1: count=%h cmp=%h unf=%b ovf=%b p=%b n=%b exp 0/0/0/0/000/111",
               count, cmp_act, flag_unf, flag_ovf, pwm_p, pwm_n);
    end
    rst = 1'b0;

    // Load shadows while stopped (R2, R9), then run with valley transfer (R7).
    step(1'b0, 2'b10, 3'b001, 16'd2, 1'b0, 1'b0);
    step(1'b0, 2'b10, 3'b010, 16'd4, 1'b0, 1'b0);
    step(1'b0, 2'b10, 3'b100, 16'd5, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) step((i % 7) != 3, 2'b10, 3'b000, 16'd0, 1'b0, 1'b0);

    // Clear both flags (R10).
    step(1'b1, 2'b10, 3'b000, 16'd0, 1'b1, 1'b1);

    // New shadows but no transfer mode (R8, R9).
    step(1'b1, 2'b00, 3'b001, 16'd1, 1'b0, 1'b0);
    step(1'b1, 2'b00, 3'b010, 16'd6, 1'b0, 1'b0);
    step(1'b1, 2'b00, 3'b100, 16'd3, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b1, 2'b00, 3'b000, 16'd0, 1'b0, 1'b0);

    // Transfer mode with writes every cycle and constant clears:
    // same-cycle write at the valley and set-over-clear (R7, R10).
    for (int i = 0; i < 40; i++)
      step(1'b1, 2'b10, 3'b111, W'(i % 9), 1'b1, (i % 5) == 0);

    // Remaining non-transfer modes (R8).
    for (int i = 0; i < 30; i++) step(1'b1, 2'b01, 3'b011, W'(i % 4), 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) step(i != 10, 2'b11, 3'b100, W'(7 - (i % 7)), 1'b0, 1'b0);

    // Final transfer picks up the last buffer values (R7).
    for (int i = 0; i < 20; i++) step(1'b1, 2'b10, 3'b000, 16'd0, 1'b0, 1'b1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule